// File: doc/BRIEF.md
# PCI Slot Hotplug Register Block

This block holds the per-slot hotplug state for a bus of up to 32 PCI slots and exposes it to firmware through a small 32-bit register port. It tracks which slots hold a device, which slots may be hot-removed, and which slots have a removal request waiting for firmware. Platform logic reports slot events (boot-time presence, hot insertion, removal request) on a single event port with a slot number. Insertion and removal requests set a hotplug bit in an event status register and can raise an interrupt.

Firmware completes a removal by writing a slot bitmap to the eject register; the lowest set bit is taken. A slot whose occupant is reported as fixed keeps its presence bit across an eject. The "device check" register is not stored. It is computed as present AND removable, so every populated hotpluggable slot reports on each read.

A platform hot-reset request makes the block drain every pending removal, one slot per clock and lowest slot first. It then rebuilds the removable mask from the fixed-device inputs and the present mask from the occupied-slot inputs. The same rebuild runs once after power-on reset.

Top module: `pci_hotplug_regs`

## Requirements
- R1: A read of offset 0x00 returns the present mask ANDed with the removable mask.
- R2: A read of offset 0x04 returns the pending-removal mask.
- R3: A write to offset 0x08 with a nonzero value ejects the slot of its lowest set bit. That slot's pending bit clears, and its present bit clears unless the fixedMask input bit of that slot is 1 at that moment. A write of zero changes nothing.
- R4: A read of offset 0x08 returns 0. A read of offset 0x0C returns the removable mask, and writes to 0x0C are ignored.
- R5: An event with kind 1 (hot-add) sets the slot's present bit and bit 1 of the event status register (offset 0x10).
- R6: An event with kind 2 (remove request) sets the slot's pending bit and bit 1 of the event status register.
- R7: An event with kind 0 (boot presence) sets the slot's present bit and leaves the event status register unchanged.
- R8: Event status bits clear when a 1 is written to them at offset 0x10. An event that sets a bit in the same cycle as the write wins over the clear.
- R9: Offset 0x14 is a read/write event enable register. irq is 1 exactly while some event status bit and its enable bit are both 1.
- R10: A hotResetReq pulse makes busy high for K+1 cycles, where K is the number of pending slots. Each busy cycle removes the lowest pending slot, using the same fixed-device rule as R3. The last busy cycle sets the removable mask to ~fixedMask and the present mask to occupiedMask.
- R11: While busy is 1, events and register writes are ignored. Reads still work.
- R12: rdData updates on the clock edge that samples rdEn and otherwise holds its value. After power-on reset, rdData and irq are 0 and busy is high for exactly one cycle while the masks are rebuilt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 5 | Byte offset; only aligned offsets decode |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| evtValid | input | 1 | Slot event strobe |
| evtKind | input | 2 | 0 boot presence, 1 hot-add, 2 remove request, 3 ignored |
| evtSlot | input | 5 | Slot number of the event |
| fixedMask | input | 32 | Slots whose occupant cannot be hot-removed |
| occupiedMask | input | 32 | Slots currently holding a device, used by the rebuild |
| hotResetReq | input | 1 | Starts drain and rebuild |
| busy | output | 1 | Drain or rebuild in progress |
| irq | output | 1 | Event interrupt |

## Verification
Every register update lands on the clock edge that samples the write or event. irq and busy follow from registers, so both are valid by the next falling edge. Read data is registered and is due on the falling edge after the rising edge that samples rdEn. The bench drives all inputs on falling edges. It queues the expected value of each read and compares it on the next falling edge, so a read issued right after a write sees that write. During a drain, reads are issued each cycle and each one shows the pending mask before that cycle's eject, which makes the lowest-first order and the one-per-cycle rate visible.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    EVT_BOOT   = 2'd0,
    EVT_ADD    = 2'd1,
    EVT_REMOVE = 2'd2,
    EVT_NONE   = 2'd3
  } evtKind_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } ctrlState_t;

  // word index of each register (byte offset / 4)
  localparam logic [2:0] IDX_UP     = 3'd0;
  localparam logic [2:0] IDX_DOWN   = 3'd1;
  localparam logic [2:0] IDX_EJECT  = 3'd2;
  localparam logic [2:0] IDX_REMOV  = 3'd3;
  localparam logic [2:0] IDX_STS    = 3'd4;
  localparam logic [2:0] IDX_STS_EN = 3'd5;

  typedef struct packed {
    logic ejectEn;
    logic rebuildEn;
    logic evtEn;
    logic stsClrEn;
    logic stsEnWrEn;
  } hpStrobe_t;

endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int W  = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[IW-1:0];
    end
    any = |vec;
  end
endmodule

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 evtValid,
  input  logic [1:0]           evtKind,
  input  logic                 hotResetReq,
  input  logic [NUM_SLOTS-1:0] pendingIn,
  output hpStrobe_t            strb,
  output logic [SLOT_W-1:0]    ejectSlot,
  output logic                 busy
);
  ctrlState_t stateQ, stateN;
  logic [SLOT_W-1:0] pendSlot, wrSlot;
  logic pendAny, wrAny, aligned, wrEject;
  logic [ADDR_W-3:0] regIdx;

  hp_lowbit #(.W(NUM_SLOTS)) i_pendLow (.vec(pendingIn), .idx(pendSlot), .any(pendAny));
  hp_lowbit #(.W(NUM_SLOTS)) i_wrLow (.vec(wrData[NUM_SLOTS-1:0]), .idx(wrSlot), .any(wrAny));

  assign aligned = (addr[1:0] == 2'b00);
  assign regIdx  = addr[ADDR_W-1:2];
  assign busy    = (stateQ == ST_DRAIN);
  assign wrEject = wrEn && aligned && (regIdx == (ADDR_W-2)'(IDX_EJECT)) && wrAny;

  always_comb begin
    stateN         = stateQ;
    strb           = '0;
    ejectSlot      = wrSlot;
    if (busy) begin
      if (pendAny) begin
        strb.ejectEn = 1'b1;
        ejectSlot    = pendSlot;
      end else begin
        strb.rebuildEn = 1'b1;
        stateN         = ST_IDLE;
      end
    end else begin
      strb.ejectEn   = wrEject;
      strb.evtEn     = evtValid && (evtKind != EVT_NONE);
      strb.stsClrEn  = wrEn && aligned && (regIdx == (ADDR_W-2)'(IDX_STS));
      strb.stsEnWrEn = wrEn && aligned && (regIdx == (ADDR_W-2)'(IDX_STS_EN));
      if (hotResetReq) stateN = ST_DRAIN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_DRAIN;
    else       stateQ <= stateN;
  end

  // R10
  drain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && pendAny |=> $countones(pendingIn) == $countones($past(pendingIn)) - 1);

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.evtEn && !strb.stsClrEn && !strb.stsEnWrEn);
endmodule

// File: rtl/hp_dpath.sv
module hp_dpath
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int STS_W     = 8,
  parameter int HP_BIT    = 1,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hpStrobe_t            strb,
  input  logic [SLOT_W-1:0]    ejectSlot,
  input  logic [1:0]           evtKind,
  input  logic [SLOT_W-1:0]    evtSlot,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_SLOTS-1:0] fixedMask,
  input  logic [NUM_SLOTS-1:0] occupiedMask,
  output logic [NUM_SLOTS-1:0] pendingOut,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irq
);
  logic [NUM_SLOTS-1:0] presentQ, presentN, enableQ, enableN, pendingQ, pendingN;
  logic [STS_W-1:0]     stsQ, stsN, stsEnQ, stsEnN;
  logic [DATA_W-1:0]    rdDataQ, rdMux;
  logic                 isAdd, isRemove, isBoot;

  assign isAdd    = strb.evtEn && (evtKind == EVT_ADD);
  assign isRemove = strb.evtEn && (evtKind == EVT_REMOVE);
  assign isBoot   = strb.evtEn && (evtKind == EVT_BOOT);

  always_comb begin
    presentN = presentQ;
    enableN  = enableQ;
    pendingN = pendingQ;
    stsN     = stsQ;
    stsEnN   = stsEnQ;
    if (strb.rebuildEn) begin
      presentN = occupiedMask;
      enableN  = ~fixedMask;
    end
    if (strb.ejectEn) begin
      pendingN[ejectSlot] = 1'b0;
      if (!fixedMask[ejectSlot]) presentN[ejectSlot] = 1'b0;
    end
    if (strb.stsClrEn)  stsN   = stsQ & ~wrData[STS_W-1:0];
    if (strb.stsEnWrEn) stsEnN = wrData[STS_W-1:0];
    if (isAdd || isBoot) presentN[evtSlot] = 1'b1;
    if (isRemove)        pendingN[evtSlot] = 1'b1;
    if (isAdd || isRemove) stsN[HP_BIT] = 1'b1;
  end

  always_comb begin
    rdMux = '0;
    if (addr[1:0] == 2'b00) begin
      case (addr[ADDR_W-1:2])
        (ADDR_W-2)'(IDX_UP):     rdMux = DATA_W'(presentQ & enableQ);
        (ADDR_W-2)'(IDX_DOWN):   rdMux = DATA_W'(pendingQ);
        (ADDR_W-2)'(IDX_REMOV):  rdMux = DATA_W'(enableQ);
        (ADDR_W-2)'(IDX_STS):    rdMux = DATA_W'(stsQ);
        (ADDR_W-2)'(IDX_STS_EN): rdMux = DATA_W'(stsEnQ);
        default:                 rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presentQ <= '0;
      enableQ  <= '0;
      pendingQ <= '0;
      stsQ     <= '0;
      stsEnQ   <= '0;
      rdDataQ  <= '0;
    end else begin
      presentQ <= presentN;
      enableQ  <= enableN;
      pendingQ <= pendingN;
      stsQ     <= stsN;
      stsEnQ   <= stsEnN;
      if (rdEn) rdDataQ <= rdMux;
    end
  end

  assign pendingOut = pendingQ;
  assign rdData     = rdDataQ;
  assign irq        = |(stsQ & stsEnQ);

  // R3
  eject_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ejectEn && !(isRemove && evtSlot == ejectSlot) |=> !pendingQ[$past(ejectSlot)]);

  // R5
  hot_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    isAdd |=> presentQ[$past(evtSlot)] && stsQ[HP_BIT]);

  // R7
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    isBoot && !strb.stsClrEn |=> $stable(stsQ));

  // R10
  rebuild_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rebuildEn |=> enableQ == ~$past(fixedMask));
endmodule

// File: rtl/pci_hotplug_regs.sv
module pci_hotplug_regs
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int STS_W     = 8,
  parameter int HP_BIT    = 1,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 evtValid,
  input  logic [1:0]           evtKind,
  input  logic [SLOT_W-1:0]    evtSlot,
  input  logic [NUM_SLOTS-1:0] fixedMask,
  input  logic [NUM_SLOTS-1:0] occupiedMask,
  input  logic                 hotResetReq,
  output logic                 busy,
  output logic                 irq
);
  hpStrobe_t            strb;
  logic [SLOT_W-1:0]    ejectSlot;
  logic [NUM_SLOTS-1:0] pending;

  hp_ctrl #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .evtValid(evtValid), .evtKind(evtKind), .hotResetReq(hotResetReq),
    .pendingIn(pending), .strb(strb), .ejectSlot(ejectSlot), .busy(busy));

  hp_dpath #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
             .STS_W(STS_W), .HP_BIT(HP_BIT)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ejectSlot(ejectSlot),
    .evtKind(evtKind), .evtSlot(evtSlot), .wrData(wrData), .rdEn(rdEn),
    .addr(addr), .fixedMask(fixedMask), .occupiedMask(occupiedMask),
    .pendingOut(pending), .rdData(rdData), .irq(irq));

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !irq);
endmodule

// File: tb/test_pci_hotplug_regs.sv
module test_pci_hotplug_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0, evtValid = 1'b0, hotResetReq = 1'b0;
  logic [4:0]  addr = '0, evtSlot = '0;
  logic [1:0]  evtKind = '0;
  logic [31:0] wrData = '0, fixedMask = 32'h9, occupiedMask = 32'hB;
  logic [31:0] rdData;
  logic        busy, irq;
  logic        rdPend = 1'b0;
  int          nVec = 0, nFail = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  pci_hotplug_regs i_pci_hotplug_regs (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtValid(evtValid), .evtKind(evtKind),
    .evtSlot(evtSlot), .fixedMask(fixedMask), .occupiedMask(occupiedMask),
    .hotResetReq(hotResetReq), .busy(busy), .irq(irq));

  always @(posedge clk) rdPend <= rdEn && rstN;

  // monitor: compares each registered read with the queued expectation
  always @(negedge clk) begin
    if (rdPend && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nVec++;
      if (rdData !== e) begin
        nFail++;
        $display("FAIL %s read: got %h expected %h", t, rdData, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic evt(input logic [1:0] k, input logic [4:0] s);
    evtValid = 1'b1; evtKind = k; evtSlot = s;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 power-on state
    chk("R12 busy after reset", {31'b0, busy}, 32'h1);
    chk("R12 rdData after reset", rdData, 32'h0);
    chk("R12 irq after reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R12 busy one cycle", {31'b0, busy}, 32'h0);
    rd(5'h0C, 32'hFFFF_FFF6, "R4 removable after rebuild");
    rd(5'h00, 32'h0000_0002, "R1 up after rebuild");
    rd(5'h04, 32'h0, "R2 down empty");
    rd(5'h08, 32'h0, "R4 eject reads zero");
    rd(5'h01, 32'h0, "R12 unaligned read zero");
    @(negedge clk);
    chk("R12 rdData holds", rdData, 32'h0);

    evt(2'd1, 5'd5);
    rd(5'h00, 32'h0000_0022, "R5 hot-add present");
    rd(5'h10, 32'h0000_0002, "R5 status bit");
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(5'h14, 32'h2);
    chk("R9 irq enabled", {31'b0, irq}, 32'h1);
    rd(5'h14, 32'h2, "R9 enable readback");
    wr(5'h10, 32'h2);
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);
    rd(5'h10, 32'h0, "R8 status cleared");

    evt(2'd0, 5'd7);
    rd(5'h00, 32'h0000_00A2, "R7 boot presence");
    rd(5'h10, 32'h0, "R7 no status");
    chk("R7 irq quiet", {31'b0, irq}, 32'h0);

    evt(2'd2, 5'd5);
    evt(2'd2, 5'd3);
    evt(2'd2, 5'd1);
    rd(5'h04, 32'h0000_002A, "R6 pending set");
    rd(5'h10, 32'h2, "R6 status bit");
    wr(5'h0C, 32'h0);
    rd(5'h0C, 32'hFFFF_FFF6, "R4 removable write ignored");
    wr(5'h08, 32'h0);
    rd(5'h04, 32'h0000_002A, "R3 zero eject no effect");
    rd(5'h00, 32'h0000_00A2, "R3 zero eject present kept");
    wr(5'h08, 32'h28);
    rd(5'h04, 32'h0000_0022, "R3 lowest slot ejected");
    fixedMask = 32'h29;
    wr(5'h08, 32'h20);
    rd(5'h04, 32'h0000_0002, "R3 fixed slot pending cleared");
    rd(5'h00, 32'h0000_00A2, "R3 fixed slot stays present");
    wr(5'h08, 32'h02);
    rd(5'h04, 32'h0, "R3 last pending cleared");
    rd(5'h00, 32'h0000_00A0, "R3 free slot not present");

    // R8 event set wins over same-cycle clear
    wrEn = 1'b1; addr = 5'h10; wrData = 32'h2;
    evtValid = 1'b1; evtKind = 2'd1; evtSlot = 5'd9;
    @(negedge clk);
    wrEn = 1'b0; evtValid = 1'b0;
    rd(5'h10, 32'h2, "R8 set wins");
    rd(5'h00, 32'h0000_02A0, "R5 slot 9 present");

    // R10 / R11 drain and rebuild
    evt(2'd2, 5'd6);
    evt(2'd2, 5'd2);
    evt(2'd2, 5'd4);
    fixedMask = 32'h100;
    occupiedMask = 32'hF01;
    hotResetReq = 1'b1;
    @(negedge clk);
    hotResetReq = 1'b0;
    chk("R10 busy drain 1", {31'b0, busy}, 32'h1);
    rdEn = 1'b1; addr = 5'h04;
    expQ.push_back(32'h54); tagQ.push_back("R10 drain start");
    evtValid = 1'b1; evtKind = 2'd1; evtSlot = 5'd20;
    wrEn = 1'b1; wrData = 32'h0;
    @(negedge clk);
    evtValid = 1'b0; wrEn = 1'b0;
    chk("R10 busy drain 2", {31'b0, busy}, 32'h1);
    expQ.push_back(32'h50); tagQ.push_back("R10 slot 2 first");
    @(negedge clk);
    chk("R10 busy drain 3", {31'b0, busy}, 32'h1);
    expQ.push_back(32'h40); tagQ.push_back("R10 slot 4 next");
    @(negedge clk);
    rdEn = 1'b0;
    chk("R10 busy rebuild cycle", {31'b0, busy}, 32'h1);
    @(negedge clk);
    chk("R10 busy done", {31'b0, busy}, 32'h0);
    rd(5'h04, 32'h0, "R10 pending empty");
    rd(5'h00, 32'h0000_0E01, "R10 present rebuilt");
    rd(5'h0C, 32'hFFFF_FEFF, "R10 removable rebuilt");
    rd(5'h14, 32'h2, "R11 enable write ignored");
    chk("R9 irq pending status", {31'b0, irq}, 32'h1);
    @(negedge clk);
    finishRun();
  end
endmodule